// File: doc/BRIEF.md
# Test Access Port Controller with Shared Serial Output

This block is a boundary-scan test access port for a chip that also contains an embedded debug-port controller. Four serial pins (test clock, mode select, data in, data out) steer a sixteen-state controller. A 4-bit instruction register picks which serial register lies between data in and data out. The standard test instructions are handled locally: bypass, identification, sample/preload and external test, which drives a small boundary-scan chain. Three debug instructions (access-port access, debug-port access, abort) give the data-out pin to the embedded debug controller. The block reports that choice on `dbg_sel` and passes the controller's serial bit through. Any other instruction code behaves as bypass.

The controller states are: Test-Logic-Reset, Run-Test/Idle, and on each of the DR and IR branches Select, Capture, Shift, Exit1, Pause, Exit2 and Update. Mode select is sampled at each rising test-clock edge. Test-Logic-Reset holds on 1 and goes to Run-Test/Idle on 0. Run-Test/Idle goes to Select-DR on 1 and holds on 0. Select-DR goes to Select-IR on 1 and Capture-DR on 0. Select-IR goes to Test-Logic-Reset on 1 and Capture-IR on 0. On each branch, Capture and Shift go to Exit1 on 1 and to Shift on 0. Exit1 goes to Update on 1 and Pause on 0. Pause holds on 0 and goes to Exit2 on 1. Exit2 goes to Update on 1 and back to Shift on 0. Update goes to Select-DR on 1 and Run-Test/Idle on 0.

All registers move on the rising test-clock edge. Data out and its enable move on the falling edge, so the bit shifted out at a rising edge has been on the pin since the falling edge before it. All shifts are least-significant bit first.

Top module: `tap_dbg_mux`

## Requirements
- R1: The controller follows the sixteen-state transition graph given above. In particular, a shift may be paused (Exit1, Pause, Exit2) and resumed with no bit lost or repeated.
- R2: Asserting `trst_n` low at any time, or holding `tms` high for five rising edges from any state, puts the controller in Test-Logic-Reset and loads IDCODE (4'b1110) into the instruction register.
- R3: Capture-IR loads 4'b0001 into the instruction shift stage, which shifts out LSB first. The active instruction changes only at the rising edge that leaves Update-IR.
- R4: With IDCODE active, Capture-DR loads the 32-bit identification value with bit 0 forced to 1, whatever the parameter holds. The value shifts out LSB first.
- R5: BYPASS (4'b1111) and every code that is not listed selects a 1-bit register. This register captures 0 in Capture-DR, so data out shows 0 and then data in delayed by one shift.
- R6: SAMPLE/PRELOAD (4'b0010) captures `bs_pin_in` in Capture-DR, with cell i holding pin i and cell 0 nearest data out. Update-DR copies the chain to `bs_pin_out`, while `bs_drive` stays 0.
- R7: EXTEST (4'b0000) uses the same chain and update as R6, and `bs_drive` is 1 while EXTEST is the active instruction.
- R8: With ABORT (4'b1000), DPACC (4'b1010) or APACC (4'b1011) active, `dbg_sel` is 1. In Shift-DR, data out then takes the value of `dbg_tdo` sampled at each falling edge.
- R9: `tdo` and `tdo_oe` change only on falling edges. `tdo_oe` is 1 only in Shift-IR and Shift-DR.
- R10: After reset, `tdo_oe`, `dbg_sel`, `bs_drive` and `bs_pin_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| dbg_tdo | input | 1 | Serial output of the embedded debug controller |
| bs_pin_in | input | BS_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, valid when tdo_oe is 1 |
| tdo_oe | output | 1 | Output enable for tdo |
| dbg_sel | output | 1 | Debug instruction active; data out belongs to the debug controller |
| bs_pin_out | output | BS_LEN | Boundary update latches |
| bs_drive | output | 1 | Boundary latches drive the pins (EXTEST) |

## Verification
The case where two functions fall in the same cycle is a mode-select reset escape that starts inside Shift-DR while EXTEST is active. On the way out, the controller passes through Update-DR, which must load the boundary latches. Three edges later, the same escape resets the instruction, which must drop `bs_drive`. The bench judges the result after the escape: `bs_pin_out` must hold the partly shifted chain, `bs_drive` must be 0, and a following DR scan must return the identification value. The second overlap is an asynchronous reset in Pause-IR with a debug code sitting in the IR shift stage. That code must never become active.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_ABORT   = 4'b1000;
    localparam logic [IR_W-1:0] OP_DPACC   = 4'b1010;
    localparam logic [IR_W-1:0] OP_APACC   = 4'b1011;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b1110;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        PATH_BYP, PATH_ID, PATH_BSR, PATH_DBG
    } path_e;

    typedef struct packed {
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
        logic to_reset;
    } tap_ctl_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tms,
    output tap_ctl_t ctl_o
);

    tap_state_e st_q, st_nx;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= TS_RESET;
        else         st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            TS_RESET:  st_nx = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   st_nx = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: st_nx = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: st_nx = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: st_nx = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: st_nx = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: st_nx = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: st_nx = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: st_nx = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: st_nx = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: st_nx = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: st_nx = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: st_nx = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: st_nx = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: st_nx = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: st_nx = tms ? TS_SEL_DR : TS_IDLE;
        endcase
    end

    always_comb begin
        ctl_o          = '0;
        ctl_o.cap_dr   = (st_q == TS_CAP_DR);
        ctl_o.shf_dr   = (st_q == TS_SHF_DR);
        ctl_o.upd_dr   = (st_q == TS_UPD_DR);
        ctl_o.cap_ir   = (st_q == TS_CAP_IR);
        ctl_o.shf_ir   = (st_q == TS_SHF_IR);
        ctl_o.upd_ir   = (st_q == TS_UPD_IR);
        ctl_o.to_reset = (st_nx == TS_RESET);
    end

    // Run of consecutive high mode-select samples, used by the check below.
    logic [2:0] hi_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              hi_run_q <= '0;
        else if (!tms)            hi_run_q <= '0;
        else if (hi_run_q != 3'd7) hi_run_q <= hi_run_q + 3'd1;
    end

    // R2
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && hi_run_q >= 3'd4) |=> (st_q == TS_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_ctl_t ctl,
    output logic     sr_lsb_o,
    output path_e    path_o,
    output logic     extest_o
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= IR_CAPTURE;
            ir_q <= OP_IDCODE;
        end else begin
            if (ctl.cap_ir)      sr_q <= IR_CAPTURE;
            else if (ctl.shf_ir) sr_q <= {tdi, sr_q[IR_W-1:1]};
            if (ctl.to_reset)    ir_q <= OP_IDCODE;
            else if (ctl.upd_ir) ir_q <= sr_q;
        end
    end

    always_comb begin
        path_o   = PATH_BYP;
        extest_o = 1'b0;
        unique case (ir_q)
            OP_EXTEST: begin
                path_o   = PATH_BSR;
                extest_o = 1'b1;
            end
            OP_SAMPLE:                     path_o = PATH_BSR;
            OP_IDCODE:                     path_o = PATH_ID;
            OP_ABORT, OP_DPACC, OP_APACC:  path_o = PATH_DBG;
            default:                       path_o = PATH_BYP;
        endcase
    end

    assign sr_lsb_o = sr_q[0];

    // R3
    ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!ctl.upd_ir && !ctl.to_reset) |=> $stable(ir_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BS_LEN = 6,
    parameter logic [31:0] ID_VAL = 32'h3A51_C0DE
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_ctl_t          ctl,
    input  path_e             path,
    input  logic              extest,
    input  logic [BS_LEN-1:0] bs_pin_in,
    output logic              dr_lsb_o,
    output logic [BS_LEN-1:0] bs_pin_out,
    output logic              bs_drive
);

    localparam int          ID_W   = 32;
    localparam logic [31:0] ID_EFF = {ID_VAL[31:1], 1'b1};

    logic              byp_q;
    logic [ID_W-1:0]   id_q;
    logic [BS_LEN-1:0] bs_q;
    logic [BS_LEN-1:0] bs_upd_q;
    logic [BS_LEN-1:0] bs_shift;

    generate
        if (BS_LEN > 1) begin : g_chain
            assign bs_shift = {tdi, bs_q[BS_LEN-1:1]};
        end else begin : g_single
            assign bs_shift = tdi;
        end
    endgenerate

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q    <= 1'b0;
            id_q     <= ID_EFF;
            bs_q     <= '0;
            bs_upd_q <= '0;
        end else begin
            if (ctl.cap_dr) begin
                byp_q <= 1'b0;
                if (path == PATH_ID)  id_q <= ID_EFF;
                if (path == PATH_BSR) bs_q <= bs_pin_in;
            end else if (ctl.shf_dr) begin
                unique case (path)
                    PATH_BYP: byp_q <= tdi;
                    PATH_ID:  id_q  <= {tdi, id_q[ID_W-1:1]};
                    PATH_BSR: bs_q  <= bs_shift;
                    default:  ;
                endcase
            end
            if (ctl.upd_dr && path == PATH_BSR) bs_upd_q <= bs_q;
        end
    end

    always_comb begin
        unique case (path)
            PATH_ID:  dr_lsb_o = id_q[0];
            PATH_BSR: dr_lsb_o = bs_q[0];
            default:  dr_lsb_o = byp_q;
        endcase
    end

    assign bs_pin_out = bs_upd_q;
    assign bs_drive   = extest;

    // R5
    byp_capture_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ctl.cap_dr |=> (byp_q == 1'b0));

endmodule

// File: rtl/tap_dbg_mux.sv
module tap_dbg_mux
    import scan_tap_pkg::*;
#(
    parameter int          BS_LEN = 6,
    parameter logic [31:0] ID_VAL = 32'h3A51_C0DE
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic              dbg_tdo,
    input  logic [BS_LEN-1:0] bs_pin_in,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              dbg_sel,
    output logic [BS_LEN-1:0] bs_pin_out,
    output logic              bs_drive
);

    tap_ctl_t ctl;
    path_e    path;
    logic     extest;
    logic     ir_lsb;
    logic     dr_lsb;
    logic     tdo_q;
    logic     oe_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .ctl_o  (ctl)
    );

    tap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .ctl      (ctl),
        .sr_lsb_o (ir_lsb),
        .path_o   (path),
        .extest_o (extest)
    );

    tap_dr #(
        .BS_LEN (BS_LEN),
        .ID_VAL (ID_VAL)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .ctl        (ctl),
        .path       (path),
        .extest     (extest),
        .bs_pin_in  (bs_pin_in),
        .dr_lsb_o   (dr_lsb),
        .bs_pin_out (bs_pin_out),
        .bs_drive   (bs_drive)
    );

    // Falling-edge output stage: the shared data-out pin and its enable.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= ctl.shf_ir | ctl.shf_dr;
            if (ctl.shf_ir)
                tdo_q <= ir_lsb;
            else if (ctl.shf_dr)
                tdo_q <= (path == PATH_DBG) ? dbg_tdo : dr_lsb;
        end
    end

    assign tdo     = tdo_q;
    assign tdo_oe  = oe_q;
    assign dbg_sel = (path == PATH_DBG);

    // R9
    oe_only_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (ctl.shf_ir || ctl.shf_dr));

    // R8
    dbg_passthru_chk: assert property (@(negedge tck) disable iff (!trst_n)
        (ctl.shf_dr && path == PATH_DBG) |=> (tdo == $past(dbg_tdo)));

endmodule

// File: tb/tap_dbg_mux_tb.sv
module tap_dbg_mux_tb;

    localparam int          TCK_PERIOD = 20;
    localparam int          BS_LEN     = 6;
    localparam logic [31:0] ID_VAL     = 32'h3A51_C0DE;
    localparam logic [31:0] ID_READ    = ID_VAL | 32'h1;

    logic              tck = 1'b0;
    logic              trst_n = 1'b0;
    logic              tms = 1'b1;
    logic              tdi = 1'b0;
    logic              dbg_tdo = 1'b0;
    logic [BS_LEN-1:0] bs_pin_in = '0;
    logic              tdo, tdo_oe, dbg_sel, bs_drive;
    logic [BS_LEN-1:0] bs_pin_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];
    logic  neg_tdo = 1'b0;
    logic  neg_oe = 1'b0;

    tap_dbg_mux #(.BS_LEN(BS_LEN), .ID_VAL(ID_VAL)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .dbg_tdo(dbg_tdo),
        .bs_pin_in(bs_pin_in), .tdo(tdo), .tdo_oe(tdo_oe), .dbg_sel(dbg_sel),
        .bs_pin_out(bs_pin_out), .bs_drive(bs_drive)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pops one expected bit for every falling edge with the output enabled.
    initial forever begin
        @(negedge tck);
        #3;
        neg_tdo = tdo;
        neg_oe  = tdo_oe;
        if (tdo_oe) begin
            if (exp_q.size() == 0) begin
                chk("R9 enable without expected bit", 1, 0);
            end else begin
                chk(tag_q.pop_front(), tdo, exp_q.pop_front());
            end
        end
    end

    // R9: data out must not move at a rising edge while enabled.
    initial forever begin
        @(posedge tck);
        #1;
        if (neg_oe) chk("R9 tdo stable at rising edge", tdo, neg_tdo);
    end

    task automatic clkd(input logic m, input logic d, input logic g);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        dbg_tdo = g;
    endtask

    task automatic settle();
        @(negedge tck);
        #2;
    endtask

    task automatic push(input int n, input logic [63:0] v, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic load_ir(input logic [3:0] code);
        clkd(1, 0, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 0, 0);
        push(4, 64'h1, "R3 capture pattern");
        for (int i = 0; i < 4; i++) clkd(i == 3, code[i], 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        settle();
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] expv,
                           input logic [63:0] gpat, input string tag);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 0, gpat[0]);
        push(n, expv, tag);
        for (int i = 0; i < n; i++) clkd(i == n - 1, din[i], gpat[i+1]);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        settle();
    endtask

    initial begin
        #(TCK_PERIOD * 100000);
        if (!done) begin
            chk("watchdog expired", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        #(TCK_PERIOD * 3);
        // R10 reset state
        chk("R10 oe in reset", tdo_oe, 0);
        chk("R10 dbg_sel in reset", dbg_sel, 0);
        chk("R10 bs_drive in reset", bs_drive, 0);
        chk("R10 bs_pin_out in reset", bs_pin_out, 0);
        @(negedge tck); #1; trst_n = 1'b1;
        clkd(0, 0, 0);
        settle();
        chk("R9 oe in idle", tdo_oe, 0);

        // R2 / R4: IDCODE is active after reset, bit 0 forced
        scan_dr(32, 64'h0, {32'h0, ID_READ}, 64'h0, "R4 idcode");

        // R5: bypass
        load_ir(4'b1111);
        chk("R5 bypass not debug", dbg_sel, 0);
        d = 64'h0000_0000_0000_00B5;
        scan_dr(8, d, {d[62:0], 1'b0}, 64'h0, "R5 bypass");

        // R1: pause and resume inside Shift-DR (bypass), bits a=1 b=0 c=1 d=1
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 0, 0);
        push(4, 64'b1010, "R1 pause resume");
        clkd(0, 1, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        settle();
        chk("R1 oe in pause", tdo_oe, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 1, 0);
        clkd(1, 1, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        settle();

        // R3: new instruction not active until Update-IR
        clkd(1, 0, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 0, 0);
        push(4, 64'h1, "R3 capture pattern");
        for (int i = 0; i < 4; i++) clkd(i == 3, OP_DP[i], 0);
        clkd(0, 0, 0);
        settle();
        chk("R3 instruction held in Pause-IR", dbg_sel, 0);
        clkd(1, 0, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        settle();
        chk("R3 R8 DPACC active after update", dbg_sel, 1);

        // R8: debug pass-through
        d = 64'h0000_0000_0000_0B2D;
        scan_dr(12, 64'hFFF, d, d, "R8 dbg passthru");
        load_ir(4'b1011);
        chk("R8 APACC selects debug", dbg_sel, 1);
        d = 64'h0000_0000_0000_0036;
        scan_dr(7, 64'h0, d, d, "R8 APACC passthru");
        load_ir(4'b1000);
        chk("R8 ABORT selects debug", dbg_sel, 1);

        // R5: unimplemented code behaves as bypass
        load_ir(4'b0101);
        chk("R5 unlisted not debug", dbg_sel, 0);
        d = 64'h0000_0000_0000_0063;
        scan_dr(8, d, {d[62:0], 1'b0}, 64'h0, "R5 unlisted bypass");

        // R6: sample/preload
        load_ir(4'b0010);
        bs_pin_in = 6'b101101;
        scan_dr(BS_LEN, 64'b010011, 64'b101101, 64'h0, "R6 sample capture");
        chk("R6 preload latches", bs_pin_out, 6'b010011);
        chk("R6 no drive", bs_drive, 0);

        // R7: extest
        load_ir(4'b0000);
        chk("R7 drive on", bs_drive, 1);
        bs_pin_in = 6'b110010;
        scan_dr(BS_LEN, 64'b001110, 64'b110010, 64'h0, "R7 extest capture");
        chk("R7 update latches", bs_pin_out, 6'b001110);

        // R2: five-high escape from Shift-DR under EXTEST (passes Update-DR)
        bs_pin_in = 6'b011001;
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 0, 0);
        push(1, 64'h1, "R7 escape first bit");
        for (int i = 0; i < 5; i++) clkd(1, 0, 0);
        settle();
        chk("R2 R7 escape update", bs_pin_out, 6'b001100);
        chk("R2 escape drops drive", bs_drive, 0);
        chk("R2 oe after escape", tdo_oe, 0);
        clkd(0, 0, 0);
        scan_dr(32, 64'h0, {32'h0, ID_READ}, 64'h0, "R2 idcode after escape");

        // R2: asynchronous reset in Pause-IR with a debug code pending
        clkd(1, 0, 0);
        clkd(1, 0, 0);
        clkd(0, 0, 0);
        clkd(0, 0, 0);
        push(4, 64'h1, "R3 capture pattern");
        for (int i = 0; i < 4; i++) clkd(i == 3, OP_DP[i], 0);
        clkd(0, 0, 0);
        @(negedge tck); #1; trst_n = 1'b0; tms = 1'b1;
        @(negedge tck); #1; trst_n = 1'b1;
        settle();
        chk("R2 trst no debug", dbg_sel, 0);
        chk("R10 trst clears latches", bs_pin_out, 0);
        clkd(0, 0, 0);
        scan_dr(32, 64'h0, {32'h0, ID_READ}, 64'h0, "R2 idcode after trst");

        settle();
        chk("R9 queue drained", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    localparam logic [3:0] OP_DP = 4'b1010;

endmodule